// File: doc/BRIEF.md
# Attribute Controller Register Port

This block is the register side of a display attribute controller. Software reaches it through one shared write port. A phase toggle inside the block decides whether each write on that port loads the register index or the data for the indexed register. A status read returns the current index and the display-access enable flag. A separate data read port returns the contents of the indexed register.

The block holds sixteen palette entries plus five control registers: mode control, border (overscan) color, bit-plane enable mask, pixel panning and color select. It presents every register value as an output. It also produces single-cycle pulses that tell downstream logic to rebuild its palette lookup or to re-evaluate the display mode. The panning value is mapped to an effective pixel shift, and the mapping depends on whether text mode is active.

The phase toggle is a two-state machine. Its states are PH_INDEX, where the next write loads the index, and PH_DATA, where the next write loads data. It has three transitions:
- LOAD_INDEX goes from PH_INDEX to PH_DATA on a write.
- LOAD_DATA goes from PH_DATA to PH_INDEX on a write.
- CLEAR goes from any state to PH_INDEX when `flip_clr` is high.

Top module: `attr_regport`

## Requirements
- R1: With `flip_clr` low, each cycle with `wr_en` high flips the phase. In PH_INDEX the write is an index write; in PH_DATA it is a data write.
- R2: Reset, or a cycle with `flip_clr` high, puts the phase in PH_INDEX. When `flip_clr` and `wr_en` are high in the same cycle, `flip_clr` wins and the write is discarded.
- R3: An index write stores `wr_data[4:0]` as the index and `wr_data[5]` as the enable flag. Both are visible one cycle later.
- R4: `stat_rd` always equals {2'b00, enable flag, index[4:0]}.
- R5: A data write to an index in 0x00..0x0F stores `wr_data[5:0]` into that palette entry, but only when the enable flag is 0. When the flag is 1 the write is discarded. The entry is output in `pal_flat` bits [6*i+5:6*i], and `rd_data` returns it zero-extended.
- R6: Data writes to the control indices take effect one cycle later:
  - 0x10 stores the 8-bit mode control value.
  - 0x11 stores the 8-bit border color.
  - 0x12 stores `wr_data[3:0]` as the plane enable mask; the upper four bits read as 0.
  - 0x13 stores the 8-bit raw pan value.
  - 0x14 stores the 8-bit color select value.

  Each of these reads back on `rd_data`.
- R7: `pal_refresh` is high for exactly the one cycle after a data write in either of these cases: a write to 0x10 that changes mode bit 7, or a write to 0x14 that changes the color select value.
- R8: `mode_chg` is high for the one cycle after a data write to 0x10 that changes mode bit 2. `blink_en` always equals mode bit 3.
- R9: When `text_mode` is 1, `pan_eff` is 0 if the raw pan value is above 7; otherwise it is the raw pan value plus 1.
- R10: When `text_mode` is 0, `pan_eff` is 0 if the raw pan value is above 7; otherwise it is the raw pan value.
- R11: A data write to any index above 0x14 changes no register. `rd_data` reads 0 for those indices.
- R12: After reset the index, all palette entries and all control registers are 0, the enable flag is 1, and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| text_mode | input | 1 | Selects the text-mode pan mapping |
| wr_en | input | 1 | Write strobe for the shared index/data port |
| wr_data | input | 8 | Write data for the shared port |
| flip_clr | input | 1 | Forces the phase back to PH_INDEX |
| stat_rd | output | 8 | Status read: enable flag and index |
| rd_data | output | 8 | Contents of the indexed register |
| pal_flat | output | 96 | Sixteen 6-bit palette entries, entry 0 in the low bits |
| mode_ctrl | output | 8 | Mode control register |
| overscan | output | 8 | Border color register |
| plane_en | output | 4 | Bit-plane enable mask |
| pan_eff | output | 4 | Effective pixel pan |
| color_sel | output | 8 | Color select register |
| blink_en | output | 1 | Blink enable (mode bit 3) |
| pal_refresh | output | 1 | Pulse requesting a rebuild of all palette entries |
| mode_chg | output | 1 | Pulse on a change of mode bit 2 |

## Verification
If the phase toggle is wrong, the effect appears on the very next write. Data lands in the index, so `stat_rd` shows the wrong index one cycle later, and every following write is decoded in the wrong role. A stale enable flag or a bad palette gate shows up in `pal_flat` one cycle after the palette write it should have blocked or let through. Refresh or mode pulses that are missing, doubled or spurious are visible in the single cycle after the data write. The bench therefore compares every output against its own model after every operation.

// File: rtl/attr_pkg.sv
package attr_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = 5;

    typedef enum logic {
        PH_INDEX = 1'b0,
        PH_DATA  = 1'b1
    } phase_t;

    localparam logic [IDX_W-1:0] IDX_MODE  = 5'h10;
    localparam logic [IDX_W-1:0] IDX_BORD  = 5'h11;
    localparam logic [IDX_W-1:0] IDX_PLANE = 5'h12;
    localparam logic [IDX_W-1:0] IDX_PAN   = 5'h13;
    localparam logic [IDX_W-1:0] IDX_CSEL  = 5'h14;

endpackage

// File: rtl/attr_phase_fsm.sv
module attr_phase_fsm
    import attr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  logic   flip_clr,
    output phase_t phase,
    output logic   idx_load,
    output logic   data_load
);

    phase_t phase_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH_INDEX;
        else        phase <= phase_nx;
    end

    // next state and decoded load strobes
    always_comb begin
        phase_nx  = phase;
        idx_load  = 1'b0;
        data_load = 1'b0;
        if (flip_clr) begin
            phase_nx = PH_INDEX;                 // CLEAR
        end else if (wr_en) begin
            unique case (phase)
                PH_INDEX: begin                  // LOAD_INDEX
                    idx_load = 1'b1;
                    phase_nx = PH_DATA;
                end
                PH_DATA: begin                   // LOAD_DATA
                    data_load = 1'b1;
                    phase_nx  = PH_INDEX;
                end
            endcase
        end
    end

    // R1
    phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flip_clr) |=> (phase != $past(phase)));

    // R2
    phase_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flip_clr |=> (phase == PH_INDEX));

endmodule

// File: rtl/attr_regfile.sv
module attr_regfile
    import attr_pkg::*;
#(
    parameter int NUM_PAL = 16,
    parameter int PAL_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     idx_load,
    input  logic                     data_load,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [IDX_W-1:0]         idx,
    output logic                     en_flag,
    output logic [NUM_PAL*PAL_W-1:0] pal_flat,
    output logic [DATA_W-1:0]        mode_q,
    output logic [DATA_W-1:0]        bord_q,
    output logic [3:0]               plane_q,
    output logic [DATA_W-1:0]        pan_q,
    output logic [DATA_W-1:0]        csel_q,
    output logic                     pal_refresh,
    output logic                     mode_chg,
    output logic [DATA_W-1:0]        rd_data
);

    localparam int               PI_W     = $clog2(NUM_PAL);
    localparam logic [IDX_W-1:0] PAL_LAST = IDX_W'(NUM_PAL - 1);

    logic [PAL_W-1:0] pal [NUM_PAL];
    logic             pal_hit;

    assign pal_hit = (idx <= PAL_LAST);

    // index and enable flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx     <= '0;
            en_flag <= 1'b1;
        end else if (idx_load) begin
            idx     <= wr_data[IDX_W-1:0];
            en_flag <= wr_data[5];
        end
    end

    // palette entries, write-locked while the enable flag is set
    for (genvar g = 0; g < NUM_PAL; g++) begin : g_pal
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pal[g] <= '0;
            else if (data_load && !en_flag && idx == IDX_W'(g))
                pal[g] <= wr_data[PAL_W-1:0];
        end
        assign pal_flat[g*PAL_W +: PAL_W] = pal[g];
    end

    // control registers and change pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= '0;
            bord_q      <= '0;
            plane_q     <= '0;
            pan_q       <= '0;
            csel_q      <= '0;
            pal_refresh <= 1'b0;
            mode_chg    <= 1'b0;
        end else begin
            pal_refresh <= 1'b0;
            mode_chg    <= 1'b0;
            if (data_load) begin
                unique case (idx)
                    IDX_MODE: begin
                        pal_refresh <= (wr_data[7] != mode_q[7]);
                        mode_chg    <= (wr_data[2] != mode_q[2]);
                        mode_q      <= wr_data;
                    end
                    IDX_BORD:  bord_q  <= wr_data;
                    IDX_PLANE: plane_q <= wr_data[3:0];
                    IDX_PAN:   pan_q   <= wr_data;
                    IDX_CSEL: begin
                        pal_refresh <= (wr_data != csel_q);
                        csel_q      <= wr_data;
                    end
                    default: ;
                endcase
            end
        end
    end

    // data read mux
    always_comb begin
        rd_data = '0;
        if (pal_hit) begin
            rd_data = {{(DATA_W-PAL_W){1'b0}}, pal[idx[PI_W-1:0]]};
        end else begin
            unique case (idx)
                IDX_MODE:  rd_data = mode_q;
                IDX_BORD:  rd_data = bord_q;
                IDX_PLANE: rd_data = {4'b0000, plane_q};
                IDX_PAN:   rd_data = pan_q;
                IDX_CSEL:  rd_data = csel_q;
                default:   rd_data = '0;
            endcase
        end
    end

    // R5
    pal_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_load && pal_hit && en_flag) |=> $stable(pal_flat));

    // R7
    refresh_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pal_refresh |-> ((mode_q[7] != $past(mode_q[7])) || (csel_q != $past(csel_q))));

    // R8
    mode_chg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |-> (mode_q[2] != $past(mode_q[2])));

    // R11
    unused_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx > IDX_CSEL) |-> (rd_data == '0));

endmodule

// File: rtl/attr_pan_map.sv
module attr_pan_map
    import attr_pkg::*;
(
    input  logic [DATA_W-1:0] pan_raw,
    input  logic              text_mode,
    output logic [3:0]        pan_eff
);

    logic in_range;

    assign in_range = (pan_raw <= 8'd7);

    always_comb begin
        if (!in_range)     pan_eff = 4'd0;
        else if (text_mode) pan_eff = pan_raw[3:0] + 4'd1;
        else               pan_eff = pan_raw[3:0];
    end

    // R9
    always_comb begin
        pan_range_chk: assert (pan_eff <= 4'd8);
    end

endmodule

// File: rtl/attr_regport.sv
module attr_regport
    import attr_pkg::*;
#(
    parameter int NUM_PAL = 16,
    parameter int PAL_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     text_mode,
    input  logic                     wr_en,
    input  logic [7:0]               wr_data,
    input  logic                     flip_clr,
    output logic [7:0]               stat_rd,
    output logic [7:0]               rd_data,
    output logic [NUM_PAL*PAL_W-1:0] pal_flat,
    output logic [7:0]               mode_ctrl,
    output logic [7:0]               overscan,
    output logic [3:0]               plane_en,
    output logic [3:0]               pan_eff,
    output logic [7:0]               color_sel,
    output logic                     blink_en,
    output logic                     pal_refresh,
    output logic                     mode_chg
);

    phase_t             phase;
    logic               idx_load;
    logic               data_load;
    logic [IDX_W-1:0]   idx;
    logic               en_flag;
    logic [DATA_W-1:0]  pan_raw;

    attr_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .flip_clr  (flip_clr),
        .phase     (phase),
        .idx_load  (idx_load),
        .data_load (data_load)
    );

    attr_regfile #(.NUM_PAL(NUM_PAL), .PAL_W(PAL_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .idx_load    (idx_load),
        .data_load   (data_load),
        .wr_data     (wr_data),
        .idx         (idx),
        .en_flag     (en_flag),
        .pal_flat    (pal_flat),
        .mode_q      (mode_ctrl),
        .bord_q      (overscan),
        .plane_q     (plane_en),
        .pan_q       (pan_raw),
        .csel_q      (color_sel),
        .pal_refresh (pal_refresh),
        .mode_chg    (mode_chg),
        .rd_data     (rd_data)
    );

    attr_pan_map u_pan (
        .pan_raw   (pan_raw),
        .text_mode (text_mode),
        .pan_eff   (pan_eff)
    );

    assign stat_rd  = {2'b00, en_flag, idx};
    assign blink_en = mode_ctrl[3];

    // R3
    idx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_load |=> (stat_rd[5:0] == $past(wr_data[5:0])));

    // R2
    clr_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_clr && wr_en) |=> ($stable(stat_rd) && $stable(pal_flat) && $stable(mode_ctrl)));

endmodule

// File: tb/attr_regport_test.sv
module attr_regport_test;

    localparam int NP = 16;
    localparam int PW = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              text_mode = 1'b0;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_data = '0;
    logic              flip_clr = 1'b0;
    logic [7:0]        stat_rd, rd_data, mode_ctrl, overscan, color_sel;
    logic [NP*PW-1:0]  pal_flat;
    logic [3:0]        plane_en, pan_eff;
    logic              blink_en, pal_refresh, mode_chg;

    always #10 clk = ~clk;

    attr_regport #(.NUM_PAL(NP), .PAL_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .text_mode(text_mode), .wr_en(wr_en),
        .wr_data(wr_data), .flip_clr(flip_clr), .stat_rd(stat_rd),
        .rd_data(rd_data), .pal_flat(pal_flat), .mode_ctrl(mode_ctrl),
        .overscan(overscan), .plane_en(plane_en), .pan_eff(pan_eff),
        .color_sel(color_sel), .blink_en(blink_en),
        .pal_refresh(pal_refresh), .mode_chg(mode_chg)
    );

    // reference model
    bit        m_data_ph;
    bit [4:0]  m_idx;
    bit        m_en;
    bit [5:0]  m_pal [NP];
    bit [7:0]  m_mode, m_bord, m_pan, m_csel;
    bit [3:0]  m_plane;
    bit        e_ref, e_mc;

    int n_chk  = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] pan_exp(input bit [7:0] r, input bit t);
        if (r > 8'd7) return 4'd0;
        return t ? (r[3:0] + 4'd1) : r[3:0];
    endfunction

    function automatic logic [NP*PW-1:0] pal_exp();
        logic [NP*PW-1:0] v;
        for (int i = 0; i < NP; i++) v[i*PW +: PW] = m_pal[i];
        return v;
    endfunction

    function automatic logic [7:0] rd_exp();
        if (m_idx < 5'd16) return {2'b00, m_pal[m_idx[3:0]]};
        case (m_idx)
            5'h10: return m_mode;
            5'h11: return m_bord;
            5'h12: return {4'b0000, m_plane};
            5'h13: return m_pan;
            5'h14: return m_csel;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_data_ph = 0; m_idx = 0; m_en = 1;
        for (int i = 0; i < NP; i++) m_pal[i] = 0;
        m_mode = 0; m_bord = 0; m_pan = 0; m_csel = 0; m_plane = 0;
        e_ref = 0; e_mc = 0;
    endtask

    task automatic check_all(input string tag);
        check(stat_rd == {2'b00, m_en, m_idx}, {tag, " R4 stat_rd"}, stat_rd, {2'b00, m_en, m_idx});
        check(rd_data == rd_exp(), {tag, " R6 rd_data"}, rd_data, rd_exp());
        check(pal_flat == pal_exp(), {tag, " R5 pal_flat"}, pal_flat, pal_exp());
        check({mode_ctrl, overscan, plane_en, color_sel} == {m_mode, m_bord, m_plane, m_csel},
              {tag, " R6 ctrl regs"}, {mode_ctrl, overscan, plane_en, color_sel},
              {m_mode, m_bord, m_plane, m_csel});
        check(pan_eff == pan_exp(m_pan, text_mode), {tag, text_mode ? " R9 pan" : " R10 pan"},
              pan_eff, pan_exp(m_pan, text_mode));
        check(blink_en == m_mode[3], {tag, " R8 blink"}, blink_en, m_mode[3]);
        check(pal_refresh == e_ref, {tag, " R7 pal_refresh"}, pal_refresh, e_ref);
        check(mode_chg == e_mc, {tag, " R8 mode_chg"}, mode_chg, e_mc);
    endtask

    // one write on the shared port; checks in the cycle after the edge
    task automatic do_write(input bit [7:0] b, input string tag);
        e_ref = 0; e_mc = 0;
        if (!m_data_ph) begin
            m_idx = b[4:0];
            m_en  = b[5];
        end else begin
            if (m_idx < 5'd16) begin
                if (!m_en) m_pal[m_idx[3:0]] = b[5:0];
            end else begin
                case (m_idx)
                    5'h10: begin
                        e_ref  = (b[7] != m_mode[7]);
                        e_mc   = (b[2] != m_mode[2]);
                        m_mode = b;
                    end
                    5'h11: m_bord  = b;
                    5'h12: m_plane = b[3:0];
                    5'h13: m_pan   = b;
                    5'h14: begin
                        e_ref  = (b != m_csel);
                        m_csel = b;
                    end
                    default: ;
                endcase
            end
        end
        m_data_ph = !m_data_ph;
        @(negedge clk);
        wr_en = 1; wr_data = b;
        @(negedge clk);
        wr_en = 0;
        check_all(tag);
    endtask

    task automatic do_clr(input bit with_wr, input bit [7:0] b, input string tag);
        e_ref = 0; e_mc = 0;
        m_data_ph = 0;
        @(negedge clk);
        flip_clr = 1; wr_en = with_wr; wr_data = b;
        @(negedge clk);
        flip_clr = 0; wr_en = 0;
        check_all(tag);
    endtask

    task automatic reg_write(input bit [4:0] i, input bit [7:0] v, input string tag);
        do_write({3'b000, i}, tag);
        do_write(v, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250607));
        model_reset();
        repeat (3) @(negedge clk);
        check_all("R12 in reset");
        rst_n = 1;
        @(negedge clk);
        check_all("R12 after reset");

        // R5: palette locked while enable flag set
        do_write(8'h23, "R3 index with enable");
        do_write(8'h15, "R5 locked palette write");
        // R5: unlocked palette write, upper bits dropped
        do_write(8'h05, "R3 index without enable");
        do_write(8'hFF, "R5 palette write");
        reg_write(5'h0F, 8'h2A, "R5 last palette entry");

        // R7 / R8 mode control
        reg_write(5'h10, 8'h80, "R7 mode bit7 set");
        reg_write(5'h10, 8'h80, "R7 mode unchanged");
        reg_write(5'h10, 8'h84, "R8 mode bit2 set");
        reg_write(5'h10, 8'h8C, "R8 blink on");
        reg_write(5'h10, 8'h08, "R7 R8 bit7 and bit2 clear");

        // R9 / R10 panning
        text_mode = 1;
        reg_write(5'h13, 8'h07, "R9 pan 7");
        reg_write(5'h13, 8'h08, "R9 pan 8");
        reg_write(5'h13, 8'h10, "R9 pan 0x10");
        reg_write(5'h13, 8'h00, "R9 pan 0");
        text_mode = 0;
        reg_write(5'h13, 8'h05, "R10 pan 5");
        reg_write(5'h13, 8'h09, "R10 pan 9");

        // R6 / R7 other registers
        reg_write(5'h11, 8'hC3, "R6 border");
        reg_write(5'h12, 8'hFA, "R6 plane mask");
        reg_write(5'h14, 8'h03, "R7 csel change");
        reg_write(5'h14, 8'h03, "R7 csel same");

        // R11 unused index
        reg_write(5'h1F, 8'hFF, "R11 unused write");
        reg_write(5'h15, 8'h55, "R11 unused write 0x15");

        // R1 / R2 toggle handling
        do_write(8'h12, "R1 index only");
        do_clr(1'b0, 8'h00, "R2 clear");
        do_write(8'h11, "R2 index after clear");
        do_clr(1'b1, 8'h3F, "R2 clear with write");
        do_write(8'h11, "R2 index after clear");
        do_write(8'h77, "R1 data after clear");

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            int unsigned sel;
            bit [7:0] b;
            sel = $urandom_range(0, 19);
            text_mode = $urandom_range(0, 1) != 0;
            if (sel == 0) begin
                do_clr($urandom_range(0, 1) != 0, 8'($urandom), "R2 random clear");
            end else if (!m_data_ph) begin
                b = 8'($urandom);
                if ($urandom_range(0, 3) != 0) b[4:0] = 5'($urandom_range(0, 21));
                do_write(b, "R3 random index");
            end else begin
                b = 8'($urandom);
                if (m_idx == 5'h14 && $urandom_range(0, 1) != 0) b = m_csel;
                if (m_idx == 5'h13 && $urandom_range(0, 1) != 0) b = 8'($urandom_range(0, 9));
                do_write(b, "R1 random data");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule